// File: doc/BRIEF.md
# Camera register initialization sequencer

This block brings up an image sensor whose registers use 16-bit addresses and 16-bit data. After a start pulse it holds the sensor in reset for a set time and then releases it. It then steps through a fixed list of register operations and hands each one, a byte at a time, to an external I2C master. That master generates START, STOP and the bit timing on the bus, and it reports an acknowledge or returned data for every command.

Most entries in the list are register writes. The list also holds three other kinds of operation. The first entry reads an identity register and keeps its value. One write is preceded by a timed wait that lets the sensor's PLL settle. Near the end, a status register is read over and over until its low byte reads zero. The block counts the register bytes that the sensor acknowledged. It judges the configuration by that count and by whether any NACK was reported.

Top module: `cam_init_seq`

## Requirements
- R1: From reset, `cam_pwdn_o` is 1 and `cam_rst_o` is 0. A `start_i` pulse seen while idle or done clears `cam_pwdn_o` and raises `cam_rst_o` for exactly RST_HOLD_CYC cycles. No command is issued before that time has elapsed.
- R2: `cmd_valid_o` stays high, with all command fields stable, until `cmd_ready_i` is sampled high. It then drops, and the next command is offered only after `rsp_valid_i`. The op encoding is 0 = write one byte, 1 = read one byte (byte field 0), 2 = STOP only.
- R3: A register write is five write commands. The first is byte 0x78 with the start flag. Then come address high, address low and data high. The last is data low with the stop flag.
- R4: A register read is six commands: 0x78 with start, address high, address low with stop, 0x79 with start, a read, and a read with nak and stop. The value is assembled from the two read responses, most significant byte first.
- R5: Entry 0 reads register 0x3000 and its value appears on `chip_id_o`. `chip_id_o` clears on start and stays 0 if that read is abandoned.
- R6: The list, in order: read 0x3000; write 0x3386=0x0501, 0x3386=0x0500, 0x3214=0x0D85, 0x341E=0x8F09, 0x341C=0x0250, 0x341E=0x8F09, 0x341E=0x8F08, 0x3202=0x0008. Then pairs of writes, 0x338C=variable and 0x3390=value, for variables 0x2797=0x0020, 0x2707=0x0280, 0x2709=0x01E0 and 0xA103=0x0002. Then a poll of 0x3390, and finally a write 0x301A=0x02CC.
- R7: The response to the last command of entry 5 and the first command of entry 6 are separated by PLL_WAIT_CYC+2 cycles. An entry without a wait has a separation of 2 cycles.
- R8: The poll entry repeats its complete read until the low byte returned is zero. The high byte does not affect this.
- R9: `wr_bytes_o` counts the address and data bytes of register writes that were acknowledged. When the sequence ends, `error_o` is set if the count is not 68, which is four per list entry minus two.
- R10: A NACK on a write command sets `error_o` and adds one to `err_cnt_o`, which saturates. If that byte did not carry the stop flag, a STOP-only command follows. The next entry then begins.
- R11: `busy_o` is high from an accepted start until the end of the list. `done_o` is then high until the next start, and `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a configuration run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has finished |
| error_o | output | 1 | A NACK occurred or the byte count is short |
| chip_id_o | output | 16 | Value read from the identity register |
| err_cnt_o | output | ERR_CNT_W | Number of NACKed write bytes, saturating |
| wr_bytes_o | output | 7 | Acknowledged register bytes written |
| cam_rst_o | output | 1 | Sensor reset, active high |
| cam_pwdn_o | output | 1 | Sensor power-down, active high |
| cmd_valid_o | output | 1 | Byte command offered to the I2C master |
| cmd_ready_i | input | 1 | The master accepts the command |
| cmd_op_o | output | 2 | 0 write byte, 1 read byte, 2 STOP only |
| cmd_start_o | output | 1 | Send START before this byte |
| cmd_stop_o | output | 1 | Send STOP after this command |
| cmd_nak_o | output | 1 | Master NACKs this received byte |
| cmd_byte_o | output | 8 | Byte to transmit |
| rsp_valid_i | input | 1 | Command completed |
| rsp_nack_i | input | 1 | The slave did not acknowledge the written byte |
| rsp_data_i | input | 8 | Byte received by a read |

## Verification
The first run acknowledges every byte. Its poll returns 0x0003, then 0x0101 (low byte nonzero, high byte nonzero), then 0x0500, so ending the poll on the low byte alone is told apart from ending it on the whole word. The second run NACKs the data-high byte of an early write, which tells apart the abort path with its extra STOP and the resulting short byte count. The third run NACKs both the address byte of the identity read and the final byte of the last write; it tells a dropped chip identity apart from a stale one, and shows that a byte already carrying STOP gets no extra STOP. A start pulse given in the middle of the first run must change neither the command stream nor the number of sensor-reset pulses.

// File: rtl/cam_init_pkg.sv
package cam_init_pkg;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_READ = 2'd1, OP_STOP = 2'd2} cmd_op_e;
  typedef enum logic [1:0] {K_WRITE = 2'd0, K_READ_ID = 2'd1, K_POLL = 2'd2} ent_kind_e;
  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_FETCH, S_WAIT, S_ISSUE, S_RSP, S_CHECK, S_DONE
  } seq_state_e;

  typedef struct packed {
    ent_kind_e   kind;
    logic        pre_wait;
    logic [15:0] addr;
    logic [15:0] data;
  } ent_t;

  localparam int unsigned NUM_ENT   = 19;
  localparam int unsigned ENT_W     = $clog2(NUM_ENT);
  localparam int unsigned STEP_W    = 3;
  localparam int unsigned EXP_BYTES = 4 * (NUM_ENT - 2);
  localparam int unsigned BYTE_W    = $clog2(EXP_BYTES + 1);
  localparam logic [6:0]  DEV_ADDR  = 7'h3C;

  function automatic ent_t mk_ent(ent_kind_e k, logic w, logic [15:0] a, logic [15:0] d);
    ent_t e;
    e.kind     = k;
    e.pre_wait = w;
    e.addr     = a;
    e.data     = d;
    return e;
  endfunction

endpackage

// File: rtl/cam_init_rom.sv
module cam_init_rom
  import cam_init_pkg::*;
(
  input  logic [ENT_W-1:0] idx_i,
  output ent_t             ent_o
);

  always_comb begin
    case (idx_i)
      5'd0:    ent_o = mk_ent(K_READ_ID, 1'b0, 16'h3000, 16'h0000);
      5'd1:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h3386, 16'h0501);
      5'd2:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h3386, 16'h0500);
      5'd3:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h3214, 16'h0D85);
      5'd4:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h341E, 16'h8F09);
      5'd5:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h341C, 16'h0250);
      5'd6:    ent_o = mk_ent(K_WRITE,   1'b1, 16'h341E, 16'h8F09);
      5'd7:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h341E, 16'h8F08);
      5'd8:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h3202, 16'h0008);
      5'd9:    ent_o = mk_ent(K_WRITE,   1'b0, 16'h338C, 16'h2797);
      5'd10:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h3390, 16'h0020);
      5'd11:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h338C, 16'h2707);
      5'd12:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h3390, 16'h0280);
      5'd13:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h338C, 16'h2709);
      5'd14:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h3390, 16'h01E0);
      5'd15:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h338C, 16'hA103);
      5'd16:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h3390, 16'h0002);
      5'd17:   ent_o = mk_ent(K_POLL,    1'b0, 16'h3390, 16'h0000);
      5'd18:   ent_o = mk_ent(K_WRITE,   1'b0, 16'h301A, 16'h02CC);
      default: ent_o = mk_ent(K_WRITE,   1'b0, 16'h301A, 16'h02CC);
    endcase
  end

endmodule

// File: rtl/cam_init_step.sv
module cam_init_step
  import cam_init_pkg::*;
(
  input  ent_t              ent_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              abort_i,
  output cmd_op_e           op_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              nak_o,
  output logic [7:0]        byte_o,
  output logic              last_o
);

  logic is_wr;
  assign is_wr  = (ent_i.kind == K_WRITE);
  assign last_o = is_wr ? (step_i == 3'd4) : (step_i == 3'd5);

  always_comb begin
    op_o    = OP_WRITE;
    start_o = 1'b0;
    stop_o  = 1'b0;
    nak_o   = 1'b0;
    byte_o  = 8'h00;
    if (abort_i) begin
      op_o   = OP_STOP;
      stop_o = 1'b1;
    end else begin
      case (step_i)
        3'd0: begin byte_o = {DEV_ADDR, 1'b0}; start_o = 1'b1; end
        3'd1: byte_o = ent_i.addr[15:8];
        3'd2: begin byte_o = ent_i.addr[7:0]; stop_o = !is_wr; end
        3'd3: begin
          if (is_wr) byte_o = ent_i.data[15:8];
          else begin byte_o = {DEV_ADDR, 1'b1}; start_o = 1'b1; end
        end
        3'd4: begin
          if (is_wr) begin byte_o = ent_i.data[7:0]; stop_o = 1'b1; end
          else op_o = OP_READ;
        end
        3'd5: begin op_o = OP_READ; nak_o = 1'b1; stop_o = 1'b1; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cam_init_timer.sv
module cam_init_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cam_init_seq.sv
module cam_init_seq
  import cam_init_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC = 20_000_000,
  parameter int unsigned PLL_WAIT_CYC = 5_000_000,
  parameter int unsigned ERR_CNT_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o,
  output logic [15:0]          chip_id_o,
  output logic [ERR_CNT_W-1:0] err_cnt_o,
  output logic [BYTE_W-1:0]    wr_bytes_o,
  output logic                 cam_rst_o,
  output logic                 cam_pwdn_o,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output logic [1:0]           cmd_op_o,
  output logic                 cmd_start_o,
  output logic                 cmd_stop_o,
  output logic                 cmd_nak_o,
  output logic [7:0]           cmd_byte_o,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_nack_i,
  input  logic [7:0]           rsp_data_i
);

  localparam int unsigned      TMAX     = (RST_HOLD_CYC > PLL_WAIT_CYC) ? RST_HOLD_CYC : PLL_WAIT_CYC;
  localparam int unsigned      TW       = $clog2(TMAX + 1);
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(NUM_ENT - 1);

  seq_state_e               st_q;
  logic [ENT_W-1:0]         ent_q;
  logic [STEP_W-1:0]        step_q;
  logic                     abort_q, err_q, pwdn_q;
  logic [ERR_CNT_W-1:0]     err_cnt_q;
  logic [BYTE_W-1:0]        bytes_q;
  logic [15:0]              chip_q;
  logic [7:0]               rd_hi_q;

  ent_t                     ent;
  cmd_op_e                  c_op;
  logic                     c_start, c_stop, c_nak, c_last;
  logic [7:0]               c_byte;
  logic                     t_load, t_zero;
  logic [TW-1:0]            t_val;
  logic                     go, nacked, poll_again, ent_fin;

  cam_init_rom u_rom (.idx_i(ent_q), .ent_o(ent));

  cam_init_step u_step (
    .ent_i(ent), .step_i(step_q), .abort_i(abort_q),
    .op_o(c_op), .start_o(c_start), .stop_o(c_stop), .nak_o(c_nak),
    .byte_o(c_byte), .last_o(c_last)
  );

  // one timer serves both the reset hold and the PLL settle wait
  assign go     = start_i && (st_q == S_IDLE || st_q == S_DONE);
  assign t_load = go || (st_q == S_FETCH && ent.pre_wait);
  assign t_val  = go ? TW'(RST_HOLD_CYC - 1) : TW'(PLL_WAIT_CYC - 1);

  cam_init_timer #(.W(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
  );

  assign nacked     = !abort_q && c_op == OP_WRITE && rsp_nack_i;
  assign poll_again = !abort_q && ent.kind == K_POLL && c_last && rsp_data_i != 8'h00;
  assign ent_fin    = abort_q || (nacked && c_stop) || (!nacked && c_last && !poll_again);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ent_q     <= '0;
      step_q    <= '0;
      abort_q   <= 1'b0;
      err_q     <= 1'b0;
      pwdn_q    <= 1'b1;
      err_cnt_q <= '0;
      bytes_q   <= '0;
      chip_q    <= '0;
      rd_hi_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: if (start_i) begin
          st_q      <= S_RST;
          ent_q     <= '0;
          step_q    <= '0;
          abort_q   <= 1'b0;
          err_q     <= 1'b0;
          pwdn_q    <= 1'b0;
          err_cnt_q <= '0;
          bytes_q   <= '0;
          chip_q    <= '0;
        end
        S_RST:   if (t_zero) st_q <= S_FETCH;
        S_FETCH: st_q <= ent.pre_wait ? S_WAIT : S_ISSUE;
        S_WAIT:  if (t_zero) st_q <= S_ISSUE;
        S_ISSUE: if (cmd_ready_i) st_q <= S_RSP;
        S_RSP: if (rsp_valid_i) begin
          if (nacked) begin
            err_q <= 1'b1;
            if (err_cnt_q != '1) err_cnt_q <= err_cnt_q + ERR_CNT_W'(1);
          end else if (!abort_q) begin
            if (ent.kind == K_WRITE && step_q != '0) bytes_q <= bytes_q + BYTE_W'(1);
            if (ent.kind != K_WRITE && step_q == 3'd4) rd_hi_q <= rsp_data_i;
            if (ent.kind == K_READ_ID && c_last) chip_q <= {rd_hi_q, rsp_data_i};
          end
          if (ent_fin) begin
            abort_q <= 1'b0;
            step_q  <= '0;
            if (ent_q == LAST_ENT) st_q <= S_CHECK;
            else begin
              ent_q <= ent_q + ENT_W'(1);
              st_q  <= S_FETCH;
            end
          end else if (nacked) begin
            abort_q <= 1'b1;
            st_q    <= S_ISSUE;
          end else if (poll_again) begin
            step_q <= '0;
            st_q   <= S_ISSUE;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st_q   <= S_ISSUE;
          end
        end
        S_CHECK: begin
          if (bytes_q != BYTE_W'(EXP_BYTES)) err_q <= 1'b1;
          st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = !(st_q == S_IDLE || st_q == S_DONE);
  assign done_o      = (st_q == S_DONE);
  assign error_o     = err_q;
  assign chip_id_o   = chip_q;
  assign err_cnt_o   = err_cnt_q;
  assign wr_bytes_o  = bytes_q;
  assign cam_rst_o   = (st_q == S_RST);
  assign cam_pwdn_o  = pwdn_q;
  assign cmd_valid_o = (st_q == S_ISSUE);
  assign cmd_op_o    = c_op;
  assign cmd_start_o = c_start;
  assign cmd_stop_o  = c_stop;
  assign cmd_nak_o   = c_nak;
  assign cmd_byte_o  = c_byte;

  assert_cmd_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_byte_o) && $stable(cmd_op_o)
      && $stable(cmd_start_o) && $stable(cmd_stop_o) && $stable(cmd_nak_o));

  assert_one_outstanding_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);

  assert_rst_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cam_rst_o |-> busy_o && !cam_pwdn_o && !cmd_valid_o);

  assert_bytes_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (wr_bytes_o == $past(wr_bytes_o)) || (wr_bytes_o == $past(wr_bytes_o) + BYTE_W'(1)));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && error_o |=> error_o);

  assert_errcnt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rsp_valid_i |=> $stable(err_cnt_o));

  assert_done_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

endmodule

// File: tb/cam_init_seq_test.sv
module cam_init_seq_test;
  import cam_init_pkg::*;

  localparam int RST_HOLD = 20;
  localparam int PLL_WAIT = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cmd_ready_i = 1'b0;
  logic rsp_valid_i = 1'b0;
  logic rsp_nack_i = 1'b0;
  logic [7:0] rsp_data_i = 8'h00;
  logic busy_o, done_o, error_o, cam_rst_o, cam_pwdn_o;
  logic [15:0] chip_id_o;
  logic [7:0] err_cnt_o;
  logic [BYTE_W-1:0] wr_bytes_o;
  logic cmd_valid_o, cmd_start_o, cmd_stop_o, cmd_nak_o;
  logic [1:0] cmd_op_o;
  logic [7:0] cmd_byte_o;

  int checks = 0, errors = 0, cyc = 0;
  int last_rsp_cyc = 0, last_valid_cyc = 0;
  int rst_pulses = 0, rst_len = 0;
  logic rst_prev = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (cam_rst_o && !rst_prev) begin rst_pulses++; rst_len = 0; end
    if (cam_rst_o) rst_len++;
    rst_prev = cam_rst_o;
  end

  cam_init_seq #(.RST_HOLD_CYC(RST_HOLD), .PLL_WAIT_CYC(PLL_WAIT), .ERR_CNT_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .chip_id_o(chip_id_o), .err_cnt_o(err_cnt_o), .wr_bytes_o(wr_bytes_o),
    .cam_rst_o(cam_rst_o), .cam_pwdn_o(cam_pwdn_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
    .cmd_start_o(cmd_start_o), .cmd_stop_o(cmd_stop_o), .cmd_nak_o(cmd_nak_o),
    .cmd_byte_o(cmd_byte_o), .rsp_valid_i(rsp_valid_i), .rsp_nack_i(rsp_nack_i),
    .rsp_data_i(rsp_data_i)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 write, 1 identity read, 2 poll read
  task automatic bench_ent(input int i, output int k, output logic [15:0] a, output logic [15:0] d);
    k = 0; d = 16'h0000;
    case (i)
      0:  begin k = 1; a = 16'h3000; end
      1:  begin a = 16'h3386; d = 16'h0501; end
      2:  begin a = 16'h3386; d = 16'h0500; end
      3:  begin a = 16'h3214; d = 16'h0D85; end
      4:  begin a = 16'h341E; d = 16'h8F09; end
      5:  begin a = 16'h341C; d = 16'h0250; end
      6:  begin a = 16'h341E; d = 16'h8F09; end
      7:  begin a = 16'h341E; d = 16'h8F08; end
      8:  begin a = 16'h3202; d = 16'h0008; end
      9:  begin a = 16'h338C; d = 16'h2797; end
      10: begin a = 16'h3390; d = 16'h0020; end
      11: begin a = 16'h338C; d = 16'h2707; end
      12: begin a = 16'h3390; d = 16'h0280; end
      13: begin a = 16'h338C; d = 16'h2709; end
      14: begin a = 16'h3390; d = 16'h01E0; end
      15: begin a = 16'h338C; d = 16'hA103; end
      16: begin a = 16'h3390; d = 16'h0002; end
      17: begin k = 2; a = 16'h3390; end
      default: begin a = 16'h301A; d = 16'h02CC; end
    endcase
  endtask

  // acts as the I2C master: checks one command, accepts it, answers it
  task automatic serve(input string tag, input logic [1:0] op, input logic st, input logic sp,
                       input logic nk, input logic [7:0] b, input logic rn, input logic [7:0] rd);
    logic [12:0] exp_f;
    exp_f = {op, st, sp, nk, b};
    while (cmd_valid_o !== 1'b1) @(negedge clk);
    last_valid_cyc = cyc;
    chk(tag, {cmd_op_o, cmd_start_o, cmd_stop_o, cmd_nak_o, cmd_byte_o}, exp_f);
    @(negedge clk);
    chk("R2 hold", {cmd_valid_o, cmd_op_o, cmd_start_o, cmd_stop_o, cmd_nak_o, cmd_byte_o}, {1'b1, exp_f});
    cmd_ready_i = 1'b1;
    @(negedge clk);
    cmd_ready_i = 1'b0;
    chk("R2 drop", cmd_valid_o, 0);
    rsp_valid_i = 1'b1; rsp_nack_i = rn; rsp_data_i = rd;
    last_rsp_cyc = cyc;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_nack_i = 1'b0; rsp_data_i = 8'h00;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_seq(input int na_e, input int na_s, input int nb_e, input int nb_s,
                         input logic [15:0] id_val, input int poll_n, input bit poke);
    int k, exp_bytes, exp_nacks, pulses0, prev_rsp, rep;
    logic [15:0] a, d, val, exp_id;
    logic [7:0] bt;
    bit hit, aborted, again;
    exp_bytes = 0; exp_nacks = 0; exp_id = 16'h0000;
    pulses0 = rst_pulses;
    pulse_start();
    chk("R11 busy after start", busy_o, 1);
    chk("R1 pwdn cleared", cam_pwdn_o, 0);
    for (int i = 0; i < NUM_ENT; i++) begin
      bench_ent(i, k, a, d);
      if (poke && i == 2) pulse_start();
      prev_rsp = last_rsp_cyc;
      if (k == 0) begin
        for (int s = 0; s < 5; s++) begin
          bt = (s == 0) ? 8'h78 : (s == 1) ? a[15:8] : (s == 2) ? a[7:0] : (s == 3) ? d[15:8] : d[7:0];
          hit = (i == na_e && s == na_s) || (i == nb_e && s == nb_s);
          serve("R3/R6 write", 2'd0, s == 0, s == 4, 1'b0, bt, hit, 8'h00);
          if (i == 6 && s == 0) chk("R7 pll wait", last_valid_cyc - prev_rsp, PLL_WAIT + 2);
          if (i == 7 && s == 0) chk("R7 no wait", last_valid_cyc - prev_rsp, 2);
          if (hit) begin
            exp_nacks++;
            if (s != 4) serve("R10 stop", 2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
            break;
          end else if (s > 0) exp_bytes++;
        end
      end else begin
        rep = 0;
        do begin
          aborted = 0;
          val = (k == 1) ? id_val : (rep < poll_n) ? ((rep == 0) ? 16'h0003 : 16'h0101) : 16'h0500;
          for (int s = 0; s < 4; s++) begin
            bt = (s == 0) ? 8'h78 : (s == 1) ? a[15:8] : (s == 2) ? a[7:0] : 8'h79;
            hit = (i == na_e && s == na_s) || (i == nb_e && s == nb_s);
            serve((k == 1) ? "R4/R5 read" : "R4/R8 poll", 2'd0, s == 0 || s == 3, s == 2, 1'b0, bt, hit, 8'h00);
            if (hit) begin
              exp_nacks++;
              if (s != 2) serve("R10 stop", 2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
              aborted = 1;
              break;
            end
          end
          if (aborted) break;
          serve("R4 read hi", 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, val[15:8]);
          serve("R4 read lo", 2'd1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, val[7:0]);
          if (k == 1) exp_id = val;
          again = (k == 2) && (val[7:0] != 8'h00);
          rep++;
        end while (again);
        if (k == 2 && !aborted) chk("R8 poll count", rep, poll_n + 1);
      end
    end
    while (done_o !== 1'b1) @(negedge clk);
    chk("R11 done", done_o, 1);
    chk("R11 busy low", busy_o, 0);
    chk("R9 byte count", wr_bytes_o, exp_bytes);
    chk("R9/R10 error", error_o, (exp_nacks > 0 || exp_bytes != EXP_BYTES) ? 1 : 0);
    chk("R10 nack count", err_cnt_o, exp_nacks);
    chk("R5 chip id", chip_id_o, exp_id);
    chk("R1/R11 one reset pulse", rst_pulses - pulses0, 1);
    chk("R1 reset length", rst_len, RST_HOLD);
    repeat (3) @(negedge clk);
    chk("R11 done held", done_o, 1);
    chk("R2 idle no cmd", cmd_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pwdn", cam_pwdn_o, 1);
    chk("R1 reset rst", cam_rst_o, 0);
    chk("R11 reset busy", busy_o, 0);
    chk("R11 reset done", done_o, 0);
    chk("R9 reset error", error_o, 0);
    chk("R2 reset valid", cmd_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle rst", cam_rst_o, 0);
    // clean run, poll low byte nonzero twice, start poked while busy
    run_seq(-1, -1, -1, -1, 16'h1580, 2, 1);
    // NACK on data-high of entry 3
    run_seq(3, 3, -1, -1, 16'h2A5C, 0, 0);
    // NACK on identity address byte and on the final stop-carrying byte
    run_seq(0, 0, 18, 4, 16'h7777, 1, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule